// File: doc/BRIEF.md
# One-Time-Enable Watchdog Timer

This block is a system watchdog. It divides a machine-cycle tick through an 8-bit prescaler with eight selectable ratios. The prescaler output then steps a 15-bit counter. When the counter wraps past its all-ones value, the block issues a one-clock reset request to the chip. Software configures it through a single 8-bit control register. Arming is permanent: after the enable bit has been written to 1, no register write can clear it. Only the watchdog's own reset request or the external reset disarms it.

To keep the request away, software writes the restart bit at intervals. This clears the prescaler and the counter together, and the bit always reads back as 0. A further control bit chooses whether the watchdog keeps counting while the device is idle. If it does not, the prescaler and the counter hold their values for as long as the idle indicator is high.

Control register layout:

| Bit | Field |
|-----|-------|
| 7 | arm |
| 6 | restart |
| 5 | run-in-idle |
| 4:3 | read as 0 |
| 2:0 | divide select |

Top module: `wdog_core`

## Requirements
- R1: After reset, `cfg_rdata` is 0x00 and `wdt_rst_o` is 0.
- R2: Writing `cfg_wdata` with bit 7 = 1 arms the watchdog, and `cfg_rdata[7]` reads 1 from the next cycle. A later write with bit 7 = 0 leaves it armed. Bits 5 and 2:0 take the written value on every write and read back in the same positions.
- R3: Writing bit 6 = 1 clears both the prescaler and the counter, and bit 6 always reads 0. If a restart is written in the same cycle as a tick, the restart takes priority.
- R4: Divide select code n (n = 0..7) makes the prescaler step the counter once every 2^(n+1) counted ticks. An overflow therefore occurs exactly 2^(n+1) * 2^CNT_W counted ticks after a restart.
- R5: While `idle_i` = 1 and run-in-idle (bit 5) = 0, ticks are not counted and the prescaler and counter hold their values.
- R6: While `idle_i` = 1 and run-in-idle = 1, ticks are counted as usual.
- R7: On overflow, `wdt_rst_o` is high for exactly one cycle, starting in the cycle after the clock edge that sampled the final tick. In that same cycle `cfg_rdata[7]` reads 0, and the prescaler and counter are zero.
- R8: The count advances only on clocks where `mc_tick` = 1 while armed. Ticks received while disarmed have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mc_tick | input | 1 | One-clock pulse per machine cycle |
| idle_i | input | 1 | High while the device is in idle |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| wdt_rst_o | output | 1 | One-clock reset request |

## Verification
A register write or a tick is sampled at one rising edge. The effect of a write shows on `cfg_rdata` from the next cycle, and an overflow produced by a tick shows on `wdt_rst_o` in the cycle after the edge that sampled it. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge, and both outputs are compared at every falling edge, so each result is read exactly one register stage after its cause. The overflow tests also count the ticks the design sampled up to the pulse and compare that count with 2^(n+1) * 2^CNT_W. The bench uses a 6-bit counter so that every divide setting completes within the run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CFG_W        = 8;
  localparam int SEL_W        = 3;
  localparam int BIT_ARM      = 7;
  localparam int BIT_RESTART  = 6;
  localparam int BIT_IDLE_RUN = 5;

  typedef struct packed {
    logic             armed;
    logic             idle_run;
    logic [SEL_W-1:0] div_sel;
  } wdog_cfg_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             expire,
  output wdog_cfg_t        cfg,
  output logic             restart,
  output logic [CFG_W-1:0] rd_data
);
  wdog_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.idle_run = wr_data[BIT_IDLE_RUN];
      cfg_d.div_sel  = wr_data[SEL_W-1:0];
      if (wr_data[BIT_ARM]) cfg_d.armed = 1'b1;
    end
    if (expire) cfg_d.armed = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign restart = wr_en & wr_data[BIT_RESTART];
  assign cfg     = cfg_q;

  always_comb begin
    rd_data               = '0;
    rd_data[BIT_ARM]      = cfg_q.armed;
    rd_data[BIT_IDLE_RUN] = cfg_q.idle_run;
    rd_data[SEL_W-1:0]    = cfg_q.div_sel;
  end

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.armed && !expire) |=> cfg_q.armed); // R2
  AST_ARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !cfg_q.armed); // R7
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRE_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [SEL_W-1:0] sel,
  output logic             stage_out
);
  logic [PRE_W-1:0] pre_q, pre_d, tap_mask;

  for (genvar g = 0; g < PRE_W; g++) begin : g_tap
    assign tap_mask[g] = (int'(sel) >= g);
  end

  assign stage_out = advance & ((pre_q & tap_mask) == tap_mask);

  always_comb begin
    pre_d = pre_q;
    if (clear)        pre_d = '0;
    else if (advance) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !advance) |=> $stable(pre_q)); // R5
  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pre_q == '0)); // R3
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign expire = step & (&cnt_q) & ~clear;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step) |=> $stable(cnt_q)); // R8
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_tick,
  input  logic             idle_i,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             wdt_rst_o
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;
  wdog_cfg_t              cfg;
  logic                   restart, advance, stage, expire, pre_clear, req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  wdog_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .expire  (expire),
    .cfg     (cfg),
    .restart (restart),
    .rd_data (cfg_rdata)
  );

  assign advance   = cfg.armed & mc_tick & ~(idle_i & ~cfg.idle_run);
  assign pre_clear = restart | expire;

  wdog_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clear     (pre_clear),
    .advance   (advance),
    .sel       (cfg.div_sel),
    .stage_out (stage)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clear  (restart),
    .step   (stage),
    .expire (expire)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) req_q <= 1'b0;
    else            req_q <= expire;
  end
  assign wdt_rst_o = req_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    wdt_rst_o |=> !wdt_rst_o); // R7
  AST_PULSE_DISARMS: assert property (@(posedge clk) disable iff (!rst_int_n)
    wdt_rst_o |-> !cfg_rdata[BIT_ARM]); // R7
  AST_RESTART_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_we |=> !cfg_rdata[BIT_RESTART]); // R3
endmodule

// File: tb/sim_wdog_core.sv
module sim_wdog_core;
  localparam int W = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_tick = 1'b0;
  logic       idle_i = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       wdt_rst_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  wdog_core #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .idle_i(idle_i),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .wdt_rst_o(wdt_rst_o)
  );

  // behavioural reference model
  bit m_en, m_run, m_rst, m_adv, m_exp;
  int m_sel, m_pre, m_cnt, np, nc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_run = 0; m_rst = 0; m_sel = 0; m_pre = 0; m_cnt = 0;
    end else begin
      m_adv = m_en && mc_tick && !(idle_i && !m_run);
      m_exp = 0; np = m_pre; nc = m_cnt;
      if (cfg_we && cfg_wdata[6]) begin
        np = 0; nc = 0;
      end else if (m_adv) begin
        np = (m_pre + 1) % 256;
        if (((m_pre + 1) % (2 << m_sel)) == 0) begin
          nc = m_cnt + 1;
          if (nc == (1 << W)) begin m_exp = 1; nc = 0; np = 0; end
        end
      end
      m_pre = np; m_cnt = nc; m_rst = m_exp;
      if (cfg_we) begin m_run = cfg_wdata[5]; m_sel = int'(cfg_wdata[2:0]); end
      if (m_exp) m_en = 0;
      else if (cfg_we && cfg_wdata[7]) m_en = 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(wdt_rst_o == m_rst, "R7 per-cycle reset request", int'(wdt_rst_o), int'(m_rst));
      check(cfg_rdata == {m_en, 1'b0, m_run, 2'b00, m_sel[2:0]},
            "R2 per-cycle register readback", int'(cfg_rdata),
            int'({m_en, 1'b0, m_run, 2'b00, m_sel[2:0]}));
    end
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0; cfg_wdata = 8'h00;
  endtask

  // tick once every gap cycles until the pulse is seen; return ticks sampled
  task automatic run_to_pulse(input int gap, output int n);
    int ph = 0;
    n = 0;
    for (int i = 0; i < 120000; i++) begin
      @(negedge clk);
      if (wdt_rst_o) begin mc_tick = 1'b0; return; end
      mc_tick = (ph == 0);
      if (ph == 0) n++;
      ph = (ph + 1) % gap;
    end
    mc_tick = 1'b0;
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) begin @(negedge clk); mc_tick = 1'b1; end
    @(negedge clk); mc_tick = 1'b0;
  endtask

  int got;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cfg_rdata == 8'h00, "R1 reset readback", int'(cfg_rdata), 0);
    check(wdt_rst_o == 1'b0, "R1 reset request low", int'(wdt_rst_o), 0);

    // R8: ticks while disarmed are ignored
    ticks(40);
    wr(8'h80);
    check(cfg_rdata[7] == 1'b1, "R2 armed after write", int'(cfg_rdata[7]), 1);
    wr(8'h00);
    check(cfg_rdata[7] == 1'b1, "R2 cannot disarm", int'(cfg_rdata[7]), 1);
    run_to_pulse(1, got);
    check(got == 2 * (1 << W), "R8 disarmed ticks ignored, sel 0", got, 2 * (1 << W));
    @(negedge clk);
    check(cfg_rdata[7] == 1'b0, "R7 disarmed after pulse", int'(cfg_rdata[7]), 0);

    // R4: divide selects
    wr(8'hC3);
    run_to_pulse(1, got);
    check(got == 16 * (1 << W), "R4 sel 3 interval", got, 16 * (1 << W));
    wr(8'hC7);
    run_to_pulse(1, got);
    check(got == 256 * (1 << W), "R4 sel 7 interval", got, 256 * (1 << W));

    // R8: sparse ticks, sel 1
    wr(8'hC1);
    run_to_pulse(3, got);
    check(got == 4 * (1 << W), "R8 sparse tick interval", got, 4 * (1 << W));

    // R3: restart mid-count
    wr(8'hC0);
    ticks(100);
    wr(8'h40);
    check(cfg_rdata[6] == 1'b0, "R3 restart bit reads zero", int'(cfg_rdata[6]), 0);
    run_to_pulse(1, got);
    check(got == 2 * (1 << W), "R3 restart resets interval", got, 2 * (1 << W));

    // R5: idle freeze
    wr(8'hC0);
    idle_i = 1'b1;
    ticks(60);
    idle_i = 1'b0;
    run_to_pulse(1, got);
    check(got == 2 * (1 << W), "R5 idle freeze holds count", got, 2 * (1 << W));

    // R6: count in idle
    wr(8'hE0);
    idle_i = 1'b1;
    run_to_pulse(1, got);
    idle_i = 1'b0;
    check(got == 2 * (1 << W), "R6 counts in idle", got, 2 * (1 << W));
    check(cfg_rdata[5] == 1'b1, "R2 run-in-idle readback", int'(cfg_rdata[5]), 1);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule